// File: doc/BRIEF.md
# Frame Memory Cycle Arbiter

This block shares one frame memory between two requesters: the display refresh path and the drawing engine. Time on the memory is cut into memory cycles of a fixed number of clocks. Each cycle is given to exactly one requester or left idle. A grant is announced at the start of a cycle and held for all of that cycle.

Two allocation schemes are supported, and the mode input selects between them. In single-access mode, used with 8-bit pixels, each cycle goes to whichever requester wins under a programmable priority. Display priority keeps the picture clean but slows drawing. Drawing priority lets drawing take any cycle, at the risk of visible corruption. In interleaved mode, used with 4-bit pixels, cycles alternate strictly between display and drawing. Each display cycle then fetches a double-width word, which the pixel path shifts out over two cycles.

The block outputs:
- the owner of the current cycle;
- a cycle-start strobe;
- the pixel depth that applies to the current cycle;
- a flag that marks a double-width display fetch.

Top module: `fb_arbiter`

## Requirements
- R1: `disp_gnt` and `draw_gnt` are never high in the same clock.
- R2: In single-access mode (`mode_il`=0) with `prio_disp`=1, a cycle requested by both requesters goes to display.
- R3: In single-access mode with `prio_disp`=0, a cycle requested by both requesters goes to drawing.
- R4: In single-access mode, a lone request is granted whatever the priority setting. With no request the cycle is idle. A requester that lost keeps its request and is granted in the next cycle in which it wins.
- R5: A memory cycle lasts `CYC_CLKS` clocks, and `cyc_start` is high in its first clock. Grants change only in that first clock and are held for the whole cycle. Each grant is decided from the requests and settings present in the last clock of the previous cycle.
- R6: In interleaved mode (`mode_il`=1), slots alternate display, drawing, display, and so on, whatever the value of `prio_disp`. The first slot after reset, or after a single-access cycle, is a display slot.
- R7: In interleaved mode, a slot whose owner is not requesting stays idle and is not given to the other requester. The alternation still advances.
- R8: `pix4` is 1 during a cycle decided in interleaved mode (4-bit pixels) and 0 during a cycle decided in single-access mode (8-bit pixels). `disp_wide` is high exactly when display owns an interleaved cycle.
- R9: Changes to `mode_il` or `prio_disp` in the middle of a memory cycle do not alter that cycle's grants or `pix4`.
- R10: While `rst_n` is low, and in the first cycle after it is released, both grants, `disp_wide` and `pix4` are 0 and `cyc_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_req | input | 1 | Display refresh request |
| draw_req | input | 1 | Drawing engine request |
| mode_il | input | 1 | Mode and pixel-depth select: 1 = interleaved, 4-bit pixels; 0 = single-access, 8-bit pixels |
| prio_disp | input | 1 | Single-access priority: 1 = display wins, 0 = drawing wins |
| disp_gnt | output | 1 | Display owns the current memory cycle |
| draw_gnt | output | 1 | Drawing owns the current memory cycle |
| disp_wide | output | 1 | The current display cycle fetches a double-width word |
| pix4 | output | 1 | Pixel depth of the current cycle: 1 = 4-bit, 0 = 8-bit |
| cyc_start | output | 1 | First clock of a memory cycle |

## Verification
The inputs seen in the last clock of a memory cycle decide the owner of the next cycle. So each result falls due exactly `CYC_CLKS` clocks after inputs are driven on a cycle-start clock. The bench waits for `cyc_start` on a falling edge, drives one vector, counts `CYC_CLKS` falling edges, and compares outputs at the following cycle start. For the mid-cycle test, outputs are also sampled on every falling edge inside the cycle, to show they stay stable until the boundary.

// File: rtl/fb_arbiter.sv
module fb_arbiter #(
  parameter int CYC_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic disp_req,
  input  logic draw_req,
  input  logic mode_il,
  input  logic prio_disp,
  output logic disp_gnt,
  output logic draw_gnt,
  output logic disp_wide,
  output logic pix4,
  output logic cyc_start
);

  localparam int PW = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);

  logic [PW-1:0] phase;
  logic          turn_draw;
  logic          nxt_disp, nxt_draw;
  logic          boundary;

  assign boundary  = (phase == LAST);
  assign cyc_start = (phase == '0);
  assign disp_wide = disp_gnt & pix4;

  always_comb begin
    if (mode_il) begin
      nxt_disp = ~turn_draw & disp_req;
      nxt_draw =  turn_draw & draw_req;
    end else if (prio_disp) begin
      nxt_disp = disp_req;
      nxt_draw = draw_req & ~disp_req;
    end else begin
      nxt_disp = disp_req & ~draw_req;
      nxt_draw = draw_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      disp_gnt  <= 1'b0;
      draw_gnt  <= 1'b0;
      pix4      <= 1'b0;
      turn_draw <= 1'b0;
    end else begin
      phase <= boundary ? '0 : phase + 1'b1;
      if (boundary) begin
        disp_gnt  <= nxt_disp;
        draw_gnt  <= nxt_draw;
        pix4      <= mode_il;
        turn_draw <= mode_il & ~turn_draw;
      end
    end
  end

endmodule

// File: rtl/fb_arbiter_chk.sv
module fb_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic disp_req,
  input logic draw_req,
  input logic mode_il,
  input logic prio_disp,
  input logic disp_gnt,
  input logic draw_gnt,
  input logic disp_wide,
  input logic pix4,
  input logic cyc_start
);

  a_r1_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_gnt && draw_gnt));

  a_r5_hold_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |-> ($stable(disp_gnt) && $stable(draw_gnt)));

  a_r9_depth_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |-> $stable(pix4));

  a_r5_disp_had_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && disp_gnt) |-> $past(disp_req));

  a_r5_draw_had_req: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && draw_gnt) |-> $past(draw_req));

  a_r8_wide_display: assert property (@(posedge clk) disable iff (!rst_n)
    disp_wide |-> (disp_gnt && pix4));

  a_r2_disp_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && draw_gnt && !pix4) |-> !($past(prio_disp) && $past(disp_req)));

endmodule

bind fb_arbiter fb_arbiter_chk u_chk (.*);

// File: tb/sim_fb_arbiter.sv
`timescale 1ns/1ps
module sim_fb_arbiter;
  localparam int NCLK = 4;
  localparam int NV   = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_req = 0, draw_req = 0, mode_il = 0, prio_disp = 0;
  logic disp_gnt, draw_gnt, disp_wide, pix4, cyc_start;
  int   nchk = 0, nbad = 0;

  always #2 clk = ~clk;

  fb_arbiter #(.CYC_CLKS(NCLK)) u0 (.*);

  // {mode_il, prio_disp, disp_req, draw_req, exp_disp, exp_draw, exp_wide}
  localparam logic [6:0] VEC [NV] = '{
    7'b0_1_11_100, // R2 both, display priority
    7'b0_0_11_010, // R3 both, drawing priority
    7'b0_1_01_010, // R4 loser now served alone
    7'b0_0_10_100, // R4 lone display under drawing priority
    7'b0_1_00_000, // R4 idle
    7'b1_0_11_101, // R6 first interleaved slot is display
    7'b1_1_11_010, // R6 draw slot despite display priority
    7'b1_0_01_000, // R7 display slot idle
    7'b1_0_10_000, // R7 draw slot idle
    7'b1_0_10_101, // R6 back to display, wide
    7'b0_1_11_100, // R8 single cycle not wide
    7'b1_0_01_000, // R6 restart on display slot
    7'b1_0_01_010  // R6 then draw slot
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic to_start();
    do @(negedge clk); while (!cyc_start);
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {disp_gnt, draw_gnt, pix4}, 3'b000);
    check("R10", {disp_wide, cyc_start, 1'b0}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {disp_gnt, draw_gnt, pix4}, 3'b000);
    to_start();

    for (int i = 0; i < NV; i++) begin
      {mode_il, prio_disp, disp_req, draw_req} = VEC[i][6:3];
      repeat (NCLK) @(negedge clk);
      check($sformatf("R1/R5 vec%0d", i), {disp_gnt, draw_gnt, disp_wide}, VEC[i][2:0]);
      check("R8", {pix4, 2'b00}, {VEC[i][6], 2'b00});
    end

    // R9: settings changed mid-cycle leave the current cycle alone
    {mode_il, prio_disp, disp_req, draw_req} = 4'b0_1_10;
    repeat (NCLK) @(negedge clk);
    check("R5", {disp_gnt, draw_gnt, pix4}, 3'b100);
    @(negedge clk);
    {mode_il, prio_disp, disp_req, draw_req} = 4'b1_0_01;
    for (int k = 1; k < NCLK; k++) begin
      check("R9", {disp_gnt, draw_gnt, pix4}, 3'b100);
      @(negedge clk);
    end
    check("R9", {disp_gnt, draw_gnt, pix4}, 3'b001);

    // R4: grant drops when request is withdrawn
    {mode_il, prio_disp, disp_req, draw_req} = 4'b0_0_01;
    repeat (NCLK) @(negedge clk);
    check("R4", {disp_gnt, draw_gnt, pix4}, 3'b010);
    draw_req = 1'b0;
    repeat (NCLK) @(negedge clk);
    check("R5", {disp_gnt, draw_gnt, cyc_start}, 3'b001);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule